// File: doc/BRIEF.md
# Colour Palette Register Port

This block is the register side of an indexed-colour output stage. It holds a 256-entry table of 24-bit colours and maps an 8-bit pixel code to red, green and blue. A bus master reaches the table through a narrow indirect interface. It writes an entry number to an index register, then writes the three colour components of that entry, one after another, to a single colour port. After the third component the index steps on by itself, so a run of consecutive entries can be loaded without rewriting the index. Every byte on the bus travels in the top byte (bits 31:24) of the 32-bit word.

The same index register also selects one of a few control registers at entry numbers 4 to 7. Register 4 is a read mask that is ANDed into every pixel code before the table is addressed. Register 6 holds overlay and cursor settings, and its two low bits drive the cursor enables. The pixel side returns the colour one clock after the code is presented.

Top module: `clut_dac_regif`

## Requirements
- R1: After reset the index register is 0, the component step is red, control register 4 (read mask) is 0xFF, control registers 5, 6 and 7 are 0, `cursor_en_o` is 0 and `rgb_o` is 0.
- R2: A write with `reg_sel_i` = 2'b00 (index) loads the entry number from bits 31:24 of `reg_wdata_i`. With `reg_sel_i` = 2'b00 the read port returns the index in bits 31:24 and zero in bits 23:0. The lower bits of the write have no effect.
- R3: Writes with `reg_sel_i` = 2'b01 (colour) take red, then green, then blue from bits 31:24. The table entry does not change until the blue write, which stores all three components together.
- R4: After each blue write the index increases by one and wraps from 255 to 0.
- R5: `rgb_o` shows the selected entry as {red[23:16], green[15:8], blue[7:0]} on the clock edge after `pix_idx_i` is presented.
- R6: The entry that is looked up is `pix_idx_i` ANDed with the read mask in control register 4.
- R7: A write with `reg_sel_i` = 2'b10 (control) loads bits 31:24 into the control register that the index selects, for index values 4 to 7. With `reg_sel_i` = 2'b10 the read port returns that register in bits 31:24 and zero elsewhere. At any other index a control write changes nothing and the read returns zero.
- R8: `cursor_en_o` equals bits 1:0 of control register 6, which is bits 25:24 of the word that wrote it. Loading 0x73 enables both cursor bits, and clearing those bits disables them.
- R9: When a blue write and a lookup of the same entry fall in the same cycle, `rgb_o` returns the old contents. A lookup in the next cycle returns the new colour.
- R10: An index write in the middle of a triple discards the red and green already written and returns the component step to red, so no entry is stored.
- R11: Control writes and `reg_sel_i` = 2'b11 leave both the index and the component step unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Target register: 00 index, 01 colour, 10 control, 11 none |
| reg_wdata_i | input | 32 | Write word; the byte payload is in bits 31:24 |
| reg_rdata_o | output | 32 | Read word for the register chosen by `reg_sel_i` |
| pix_idx_i | input | 8 | Pixel code to look up |
| rgb_o | output | 24 | Looked-up colour, one cycle of latency |
| cursor_en_o | output | 2 | Cursor enable bits from control register 6 |

## Verification
A blue write that stores an entry can fall in the same clock as a pixel lookup of that same entry. The bench forces this case by driving both in one cycle, after first loading the entry with a known colour. It expects the old colour from that lookup and the new colour from a second lookup one cycle later. A change of the read mask that comes right before a lookup is also tested, so the bench can tell whether the masked code is used.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'b00,
    SEL_DATA = 2'b01,
    SEL_CTRL = 2'b10,
    SEL_NONE = 2'b11
  } reg_sel_e;

  typedef enum logic [1:0] {
    COMP_R = 2'd0,
    COMP_G = 2'd1,
    COMP_B = 2'd2
  } comp_e;
endpackage

// File: rtl/clut_addr_seq.sv
module clut_addr_seq
  import clut_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int COMP_W = 8,
  parameter int IDX_W  = 8,
  localparam int RGB_W = 3 * COMP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              commit_o,
  output logic [IDX_W-1:0]  commit_idx_o,
  output logic [RGB_W-1:0]  commit_rgb_o
);
  comp_e               comp_q;
  logic [IDX_W-1:0]    idx_q;
  logic [COMP_W-1:0]   red_q, grn_q;
  logic [COMP_W-1:0]   lane;
  logic                wr_addr, wr_data, wr_ctrl;

  assign lane    = wdata_i[BUS_W-1 -: COMP_W];
  assign wr_addr = we_i && (sel_i == SEL_ADDR);
  assign wr_data = we_i && (sel_i == SEL_DATA);
  assign wr_ctrl = we_i && (sel_i == SEL_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      comp_q <= COMP_R;
      red_q  <= '0;
      grn_q  <= '0;
    end else if (wr_addr) begin
      idx_q  <= wdata_i[BUS_W-1 -: IDX_W];
      comp_q <= COMP_R;
    end else if (wr_data) begin
      case (comp_q)
        COMP_R: begin red_q <= lane; comp_q <= COMP_G; end
        COMP_G: begin grn_q <= lane; comp_q <= COMP_B; end
        default: begin
          comp_q <= COMP_R;
          idx_q  <= idx_q + 1'b1;
        end
      endcase
    end
  end

  assign commit_o     = wr_data && (comp_q == COMP_B);
  assign commit_idx_o = idx_q;
  assign commit_rgb_o = {red_q, grn_q, lane};
  assign idx_o        = idx_q;

  // R10
  addr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_addr |=> (comp_q == COMP_R) && (idx_q == $past(wdata_i[BUS_W-1 -: IDX_W])));

  // R4
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> idx_q == IDX_W'($past(idx_q) + 1'b1));

  // R3
  commit_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> comp_q == COMP_R);

  // R11
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl || !we_i || sel_i == SEL_NONE) |=> $stable(idx_q) && $stable(comp_q));
endmodule

// File: rtl/clut_ctrl_bank.sv
module clut_ctrl_bank
  import clut_pkg::*;
#(
  parameter int BUS_W     = 32,
  parameter int COMP_W    = 8,
  parameter int IDX_W     = 8,
  parameter int CTRL_BASE = 4,
  parameter int CTRL_NUM  = 4,
  parameter int MASK_IDX  = 4,
  parameter int CURS_IDX  = 6,
  localparam int OFF_W    = (CTRL_NUM > 1) ? $clog2(CTRL_NUM) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [COMP_W-1:0] rdata_o,
  output logic [COMP_W-1:0] mask_o,
  output logic [1:0]        cursor_o
);
  logic [COMP_W-1:0]          ctrl_q [CTRL_NUM];
  logic [CTRL_NUM*COMP_W-1:0] ctrl_flat;
  logic                       hit;
  logic [IDX_W-1:0]           off_full;
  logic [OFF_W-1:0]           off;
  logic                       wr_ctrl;

  assign wr_ctrl  = we_i && (sel_i == SEL_CTRL);
  assign hit      = (idx_i >= IDX_W'(CTRL_BASE)) && (idx_i < IDX_W'(CTRL_BASE + CTRL_NUM));
  assign off_full = idx_i - IDX_W'(CTRL_BASE);
  assign off      = off_full[OFF_W-1:0];

  for (genvar k = 0; k < CTRL_NUM; k++) begin : g_reg
    localparam logic [COMP_W-1:0] RST_VAL = (CTRL_BASE + k == MASK_IDX) ? '1 : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        ctrl_q[k] <= RST_VAL;
      else if (wr_ctrl && idx_i == IDX_W'(CTRL_BASE + k))
        ctrl_q[k] <= wdata_i[BUS_W-1 -: COMP_W];
    end
    assign ctrl_flat[k*COMP_W +: COMP_W] = ctrl_q[k];
  end

  assign rdata_o  = hit ? ctrl_q[off] : '0;
  assign mask_o   = ctrl_q[MASK_IDX - CTRL_BASE];
  assign cursor_o = ctrl_q[CURS_IDX - CTRL_BASE][1:0];

  // R8
  cursor_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && idx_i == IDX_W'(CURS_IDX)) |=> cursor_o == $past(wdata_i[BUS_W-COMP_W +: 2]));

  // R7
  ctrl_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !hit) |=> $stable(ctrl_flat));

  // R6
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && idx_i == IDX_W'(MASK_IDX)) |=> mask_o == $past(wdata_i[BUS_W-1 -: COMP_W]));
endmodule

// File: rtl/clut_ram.sv
module clut_ram #(
  parameter int IDX_W  = 8,
  parameter int RGB_W  = 24,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [RGB_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [RGB_W-1:0] rdata_o
);
  logic [RGB_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // read-before-write on a same-entry collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem[raddr_i];
  end

  // R9
  collide_old_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && raddr_i == waddr_i && $past(we_i) == 1'b0 && $past(raddr_i) == raddr_i)
      |=> rdata_o == $past(rdata_o));
endmodule

// File: rtl/clut_dac_regif.sv
module clut_dac_regif
  import clut_pkg::*;
#(
  parameter int BUS_W     = 32,
  parameter int COMP_W    = 8,
  parameter int IDX_W     = 8,
  parameter int CTRL_BASE = 4,
  parameter int CTRL_NUM  = 4,
  parameter int MASK_IDX  = 4,
  parameter int CURS_IDX  = 6,
  localparam int RGB_W    = 3 * COMP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [BUS_W-1:0]  reg_wdata_i,
  output logic [BUS_W-1:0]  reg_rdata_o,
  input  logic [IDX_W-1:0]  pix_idx_i,
  output logic [RGB_W-1:0]  rgb_o,
  output logic [1:0]        cursor_en_o
);
  logic [IDX_W-1:0]  idx;
  logic              commit;
  logic [IDX_W-1:0]  commit_idx;
  logic [RGB_W-1:0]  commit_rgb;
  logic [COMP_W-1:0] ctrl_rd, mask;
  logic [IDX_W-1:0]  look_idx;

  clut_addr_seq #(.BUS_W(BUS_W), .COMP_W(COMP_W), .IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .idx_o(idx), .commit_o(commit),
    .commit_idx_o(commit_idx), .commit_rgb_o(commit_rgb)
  );

  clut_ctrl_bank #(
    .BUS_W(BUS_W), .COMP_W(COMP_W), .IDX_W(IDX_W), .CTRL_BASE(CTRL_BASE),
    .CTRL_NUM(CTRL_NUM), .MASK_IDX(MASK_IDX), .CURS_IDX(CURS_IDX)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .idx_i(idx), .wdata_i(reg_wdata_i),
    .rdata_o(ctrl_rd), .mask_o(mask), .cursor_o(cursor_en_o)
  );

  assign look_idx = pix_idx_i & mask[IDX_W-1:0];

  clut_ram #(.IDX_W(IDX_W), .RGB_W(RGB_W)) u_ram (
    .clk_i, .rst_ni,
    .we_i(commit), .waddr_i(commit_idx), .wdata_i(commit_rgb),
    .raddr_i(look_idx), .rdata_o(rgb_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_sel_i)
      SEL_ADDR: reg_rdata_o[BUS_W-1 -: IDX_W]  = idx;
      SEL_CTRL: reg_rdata_o[BUS_W-1 -: COMP_W] = ctrl_rd;
      default:  reg_rdata_o = '0;
    endcase
  end

  // R2
  rdata_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[BUS_W-COMP_W-1:0] == '0);
endmodule

// File: tb/clut_dac_regif_bench.sv
`timescale 1ns/1ps
module clut_dac_regif_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_sel_i = 2'b11;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [7:0]  pix_idx_i = '0;
  logic [23:0] rgb_o;
  logic [1:0]  cursor_en_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  clut_dac_regif u_clut_dac_regif (
    .clk_i(clk), .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i, .reg_rdata_o,
    .pix_idx_i, .rgb_o, .cursor_en_o
  );

  // reference model built from the requirements
  logic [23:0] mdl [256];
  logic [7:0]  m_idx = 8'h00;
  int          m_cnt = 0;
  logic [7:0]  m_r = 8'h00, m_g = 8'h00;
  logic [7:0]  m_ctrl [4] = '{8'hFF, 8'h00, 8'h00, 8'h00};

  logic [23:0] exp_q [$];
  string       tag_q [$];
  logic        look_req = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void model_wr(logic [1:0] sel, logic [31:0] d);
    if (sel == 2'b00) begin
      m_idx = d[31:24]; m_cnt = 0;
    end else if (sel == 2'b01) begin
      if (m_cnt == 0) begin m_r = d[31:24]; m_cnt = 1; end
      else if (m_cnt == 1) begin m_g = d[31:24]; m_cnt = 2; end
      else begin mdl[m_idx] = {m_r, m_g, d[31:24]}; m_idx = m_idx + 8'd1; m_cnt = 0; end
    end else if (sel == 2'b10) begin
      if (m_idx >= 8'd4 && m_idx <= 8'd7) m_ctrl[m_idx - 8'd4] = d[31:24];
    end
  endfunction

  // driver tasks: called at a falling edge, return at the next one
  task automatic do_wr(logic [1:0] sel, logic [31:0] d);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    model_wr(sel, d);
    @(negedge clk);
    reg_we_i = 1'b0; reg_sel_i = 2'b11; reg_wdata_i = 32'h0;
  endtask

  task automatic lookup(logic [7:0] idx, string tag);
    pix_idx_i = idx; look_req = 1'b1;
    exp_q.push_back(mdl[idx & m_ctrl[0]]); tag_q.push_back(tag);
    @(negedge clk);
    look_req = 1'b0;
  endtask

  task automatic wr_and_look(logic [31:0] d, logic [7:0] idx, string tag);
    pix_idx_i = idx; look_req = 1'b1;
    exp_q.push_back(mdl[idx & m_ctrl[0]]); tag_q.push_back(tag);
    reg_we_i = 1'b1; reg_sel_i = 2'b01; reg_wdata_i = d;
    model_wr(2'b01, d);
    @(negedge clk);
    reg_we_i = 1'b0; reg_sel_i = 2'b11; look_req = 1'b0;
  endtask

  task automatic triple(logic [23:0] c);
    do_wr(2'b01, {c[23:16], 24'h5A5A5A});
    do_wr(2'b01, {c[15:8],  24'hA5A5A5});
    do_wr(2'b01, {c[7:0],   24'h0F0F0F});
  endtask

  task automatic rd(logic [1:0] sel, logic [31:0] exp, string tag);
    reg_sel_i = sel; #1;
    chk(tag, reg_rdata_o, exp);
    reg_sel_i = 2'b11;
  endtask

  // monitor: pops one expectation for each lookup after its sampling edge
  always @(posedge clk) begin
    if (look_req) begin
      #1;
      if (exp_q.size() == 0) chk("scoreboard underflow", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), {8'h0, rgb_o}, {8'h0, exp_q.pop_front()});
    end
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rgb reset", {8'h0, rgb_o}, 32'h0);
    chk("R1 cursor reset", {30'h0, cursor_en_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(2'b00, 32'h0, "R1 index reset");
    do_wr(2'b00, 32'h04000000); rd(2'b10, 32'hFF000000, "R1 mask reset");
    do_wr(2'b00, 32'h06000000); rd(2'b10, 32'h00000000, "R1 ctrl6 reset");

    // initialisation sequence
    do_wr(2'b00, 32'h04000000); do_wr(2'b10, 32'hFF000000);
    do_wr(2'b00, 32'h05000000); do_wr(2'b10, 32'h00000000);
    do_wr(2'b00, 32'h06000000); do_wr(2'b10, 32'h73123456);
    chk("R8 cursor on", {30'h0, cursor_en_o}, 32'h3);
    rd(2'b10, 32'h73000000, "R7 ctrl6 readback");
    do_wr(2'b00, 32'h07000000); do_wr(2'b10, 32'h00000000);

    // out-of-range control write
    do_wr(2'b00, 32'h02000000); do_wr(2'b10, 32'hAB000000);
    rd(2'b10, 32'h0, "R7 out-of-range read");
    do_wr(2'b00, 32'h04000000); rd(2'b10, 32'hFF000000, "R7 mask untouched");

    // index load with junk low bits
    do_wr(2'b00, 32'h10ABCDEF);
    rd(2'b00, 32'h10000000, "R2 index readback");

    // basic load and lookup
    triple(24'hAABBCC);
    lookup(8'h10, "R5 entry 10");
    rd(2'b00, 32'h11000000, "R4 index step");

    // partial triple must not commit
    do_wr(2'b00, 32'h10000000);
    do_wr(2'b01, 32'h11000000); do_wr(2'b01, 32'h22000000);
    lookup(8'h10, "R3 no commit before blue");
    do_wr(2'b01, 32'h33000000);
    lookup(8'h10, "R3 commit on blue");

    // index rewrite mid-triple
    do_wr(2'b00, 32'h20000000);
    do_wr(2'b01, 32'h01000000); do_wr(2'b01, 32'h02000000);
    do_wr(2'b00, 32'h20000000);
    triple(24'h445566);
    lookup(8'h20, "R10 restart at red");

    // control write inside a triple
    do_wr(2'b00, 32'h30000000);
    do_wr(2'b01, 32'h07000000);
    do_wr(2'b10, 32'hEE000000);
    do_wr(2'b11, 32'h99000000);
    do_wr(2'b01, 32'h08000000); do_wr(2'b01, 32'h09000000);
    lookup(8'h30, "R11 sequence kept");
    rd(2'b00, 32'h31000000, "R11 index after");

    // streaming consecutive entries
    do_wr(2'b00, 32'h40000000);
    triple(24'h010203); triple(24'h040506); triple(24'h070809);
    lookup(8'h40, "R4 stream 0");
    lookup(8'h41, "R4 stream 1");
    lookup(8'h42, "R4 stream 2");

    // wrap from 255 to 0
    do_wr(2'b00, 32'hFF000000);
    triple(24'hF0E0D0);
    rd(2'b00, 32'h00000000, "R4 wrap index");
    triple(24'h0A0B0C);
    lookup(8'hFF, "R4 entry ff");
    lookup(8'h00, "R4 entry 00 after wrap");

    // read mask
    do_wr(2'b00, 32'h0F000000);
    triple(24'h123456);
    do_wr(2'b00, 32'h04000000); do_wr(2'b10, 32'h0F000000);
    lookup(8'hFF, "R6 masked to 0f");
    lookup(8'h40, "R6 masked to 00");
    do_wr(2'b10, 32'hFF000000);
    lookup(8'h40, "R6 mask restored");

    // same-cycle commit and lookup
    do_wr(2'b00, 32'h50000000);
    triple(24'h111111);
    do_wr(2'b00, 32'h50000000);
    do_wr(2'b01, 32'h77000000); do_wr(2'b01, 32'h88000000);
    wr_and_look(32'h99000000, 8'h50, "R9 old value on collision");
    lookup(8'h50, "R9 new value next cycle");

    // cursor disable
    do_wr(2'b00, 32'h06000000); do_wr(2'b10, 32'h70000000);
    chk("R8 cursor off", {30'h0, cursor_en_o}, 32'h0);
    rd(2'b10, 32'h70000000, "R8 ctrl6 after clear");

    repeat (3) @(negedge clk);
    chk("R5 scoreboard drained", exp_q.size(), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule